// File: doc/BRIEF.md
# UART Interrupt Line Generator

This block merges four UART interrupt sources into one active-high interrupt request. The sources are modem status change, transmitter holding register empty, received data available and receiver line status error. Each source has its own pending flag. An event pulse sets the flag, and the register access that services that source clears it. A 4-bit enable register masks the flags before they reach the line. A priority encoder reports the most urgent enabled pending source as a 3-bit identification code.

The `legacy_mode` input selects how the line behaves when several sources are pending together. In level mode the line stays high for as long as any enabled source is pending. In legacy mode the line drops for exactly one clock each time a source is serviced while others are still pending. That drop gives an edge-triggered interrupt controller a fresh rising edge for each source.

The block has a second output, `irq_edge`, for controllers that need edges in level mode. It is the interrupt ANDed with an active-low bus-access strobe, so every access to the UART forces a falling and then a rising edge. Software that uses this output must tolerate one spurious request. Writing 0x0 to the enable register and then writing back the wanted bits is a pure software way to get an edge.

Top module: `uart_irq_line_gen`

## Requirements
- R1: While reset is asserted and after it is released, `irq` and `irq_edge` are 0, `irq_id` is 3'b001 (nothing pending) and `ier_rdata` is 0.
- R2: A pending source whose enable bit is 0 changes neither `irq` nor `irq_id`. Once its enable bit is set, it asserts `irq` and shows its code one cycle after the enable write.
- R3: `irq_id` reports the highest-priority enabled pending source. Priority and codes are: line status (bit 0) 3'b110, received data (bit 1) 3'b100, transmitter empty (bit 2) 3'b010, modem status (bit 3) 3'b000, none 3'b001.
- R4: Each source is cleared by its own service strobe: `lsr_rd` clears bit 0, `rbr_rd` clears bit 1, `thr_wr` clears bit 2 and `msr_rd` clears bit 3. The clear is visible on the outputs one cycle after the strobe.
- R5: `iir_rd` clears the transmitter-empty source only when `irq_id` currently reports it (3'b010). Otherwise `iir_rd` has no effect.
- R6: When a set pulse and a service strobe hit the same source in the same cycle, the source stays pending.
- R7: With `legacy_mode` = 0, `irq` stays high without a gap while any enabled source is still pending after another source is serviced.
- R8: With `legacy_mode` = 1, servicing an enabled source while another enabled source remains pending drives `irq` low for exactly the one cycle that follows the clearing edge. `irq` is high again on the next cycle.
- R9: With `legacy_mode` = 1, servicing the last enabled pending source drops `irq` and keeps it low.
- R10: Writing 0x0 to the enable register drops `irq` on the next cycle without losing the pending flags. Writing the enable bits back re-asserts `irq` on the cycle after that write.
- R11: `irq_edge` equals `irq` while `bus_strobe_n` is 1 and is 0 while `bus_strobe_n` is 0, with no clock delay.
- R12: An enable write takes effect at the next clock edge, and `ier_rdata` shows the written value from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| legacy_mode | input | 1 | 1: one-cycle drop per serviced source; 0: steady level |
| src_set | input | 4 | Event pulses setting pending flags (bit 0 line, 1 rx data, 2 tx empty, 3 modem) |
| lsr_rd | input | 1 | Line status read, services bit 0 |
| rbr_rd | input | 1 | Receive buffer read, services bit 1 |
| thr_wr | input | 1 | Holding register write, services bit 2 |
| iir_rd | input | 1 | Identification read, services bit 2 when it is the reported source |
| msr_rd | input | 1 | Modem status read, services bit 3 |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 4 | Enable register write data |
| bus_strobe_n | input | 1 | Active-low strobe, low during any UART access |
| ier_rdata | output | 4 | Current enable register contents |
| irq_id | output | 3 | Identification code of the highest enabled pending source |
| irq | output | 1 | Interrupt request line |
| irq_edge | output | 1 | `irq` ANDed with `bus_strobe_n` |

## Verification
A pending flag stuck set, or one that was never set, shows at once in `irq_id`, one cycle after the set pulse or service strobe. The trap is a flag hidden behind a higher-priority source: it only becomes visible once the sources above it are serviced, so the tests walk down the priority chain one service at a time. If the gap register sticks or fails to fire, `irq` in legacy mode is wrong in the one cycle that follows the clearing edge, so the checks sample both that cycle and the one after it. A fault in the enable mask shows up as a wrong `irq` on the cycle after an enable write.

// File: rtl/irq_gen_pkg.sv
package irq_gen_pkg;

  localparam int NSRC = 4;
  localparam int IDW  = 3;

  // source bit positions, lower index = higher priority
  localparam int SRC_LINE = 0;
  localparam int SRC_RXD  = 1;
  localparam int SRC_TXE  = 2;
  localparam int SRC_MDM  = 3;

  typedef enum logic [IDW-1:0] {
    ID_MDM  = 3'b000,
    ID_NONE = 3'b001,
    ID_TXE  = 3'b010,
    ID_RXD  = 3'b100,
    ID_LINE = 3'b110
  } irq_id_e;

  function automatic irq_id_e src_code(input int idx);
    case (idx)
      SRC_LINE: return ID_LINE;
      SRC_RXD:  return ID_RXD;
      SRC_TXE:  return ID_TXE;
      default:  return ID_MDM;
    endcase
  endfunction

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_q,
  output logic [N-1:0] pend_d
);

  for (genvar g = 0; g < N; g++) begin : g_flag
    logic upd_en;

    always_comb begin
      upd_en    = set_i[g] | clr_i[g];
      pend_d[g] = set_i[g] | (pend_q[g] & ~clr_i[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend_q[g] <= 1'b0;
      else if (upd_en) pend_q[g] <= pend_d[g];
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> pend_q[g]);                                   // R6
    AST_CLR_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !set_i[g]) |=> !pend_q[g]);                   // R4
  end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_gen_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0]   masked_i,
  output logic [IDW-1:0] id_o
);

  always_comb begin
    id_o = ID_NONE;
    for (int i = N - 1; i >= 0; i--) begin
      if (masked_i[i]) id_o = src_code(i);
    end
  end

endmodule

// File: rtl/irq_line_shaper.sv
module irq_line_shaper #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         legacy_i,
  input  logic [N-1:0] masked_d,
  input  logic [N-1:0] masked_q,
  input  logic         hit_i,
  output logic         irq_q
);

  logic gap_d;
  logic irq_d;
  logic legacy_q;

  always_comb begin
    gap_d = legacy_i & hit_i & (|masked_d);
    irq_d = (|masked_d) & ~gap_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q    <= 1'b0;
      legacy_q <= 1'b0;
    end else begin
      irq_q    <= irq_d;
      legacy_q <= legacy_i;
    end
  end

  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!legacy_i && !legacy_q && (|masked_q)) |-> irq_q);          // R7
  AST_GAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (legacy_i && !irq_q && (|masked_d) && !hit_i) |=> irq_q);   // R8
  AST_NONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (masked_q == '0) |-> !irq_q);                                // R9

endmodule

// File: rtl/uart_irq_line_gen.sv
module uart_irq_line_gen
  import irq_gen_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            legacy_mode,
  input  logic [NSRC-1:0] src_set,
  input  logic            lsr_rd,
  input  logic            rbr_rd,
  input  logic            thr_wr,
  input  logic            iir_rd,
  input  logic            msr_rd,
  input  logic            ier_wr,
  input  logic [NSRC-1:0] ier_wdata,
  input  logic            bus_strobe_n,
  output logic [NSRC-1:0] ier_rdata,
  output logic [IDW-1:0]  irq_id,
  output logic            irq,
  output logic            irq_edge
);

  logic [1:0]      rsync_q;
  logic            rst_sync_n;
  logic [NSRC-1:0] ier_q;
  logic [NSRC-1:0] ier_d;
  logic [NSRC-1:0] clr;
  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] pend_d;
  logic [NSRC-1:0] masked_q;
  logic [NSRC-1:0] masked_d;
  logic            hit;
  logic            irq_q;

  // reset: asserted asynchronously, released after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  // enable register
  always_comb ier_d = ier_wr ? ier_wdata : ier_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  ier_q <= '0;
    else if (ier_wr)  ier_q <= ier_wdata;
  end

  // service strobes
  always_comb begin
    clr           = '0;
    clr[SRC_LINE] = lsr_rd;
    clr[SRC_RXD]  = rbr_rd;
    clr[SRC_TXE]  = thr_wr | (iir_rd & (irq_id == ID_TXE));
    clr[SRC_MDM]  = msr_rd;
  end

  irq_pend_bank #(.N(NSRC)) u_pend (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set_i  (src_set),
    .clr_i  (clr),
    .pend_q (pend_q),
    .pend_d (pend_d)
  );

  always_comb begin
    masked_q = pend_q & ier_q;
    masked_d = pend_d & ier_d;
    hit      = |(masked_q & clr & ~src_set);
  end

  irq_prio_enc #(.N(NSRC)) u_enc (
    .masked_i (masked_q),
    .id_o     (irq_id)
  );

  irq_line_shaper #(.N(NSRC)) u_shape (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .legacy_i (legacy_mode),
    .masked_d (masked_d),
    .masked_q (masked_q),
    .hit_i    (hit),
    .irq_q    (irq_q)
  );

  assign irq       = irq_q;
  assign irq_edge  = irq_q & bus_strobe_n;
  assign ier_rdata = ier_q;

  AST_ID_WHEN_IRQ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq |-> (irq_id != ID_NONE));                                // R3
  AST_IER_ZERO_DROPS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ier_wr && ier_wdata == '0) |=> !irq);                       // R10
  AST_EDGE_GATED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !bus_strobe_n |-> !irq_edge);                                // R11
  AST_IIR_TXE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (iir_rd && irq_id == ID_TXE && !src_set[SRC_TXE]) |=> !pend_q[SRC_TXE]); // R5
  AST_IER_TAKES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ier_wr |=> (ier_rdata == $past(ier_wdata)));                 // R12

endmodule

// File: tb/sim_uart_irq_line_gen.sv
`timescale 1ns/1ps
module sim_uart_irq_line_gen;

  logic       clk;
  logic       rst_n;
  logic       legacy_mode;
  logic [3:0] src_set;
  logic       lsr_rd, rbr_rd, thr_wr, iir_rd, msr_rd;
  logic       ier_wr;
  logic [3:0] ier_wdata;
  logic       bus_strobe_n;
  logic [3:0] ier_rdata;
  logic [2:0] irq_id;
  logic       irq;
  logic       irq_edge;

  int n_chk;
  int n_bad;

  uart_irq_line_gen u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .legacy_mode  (legacy_mode),
    .src_set      (src_set),
    .lsr_rd       (lsr_rd),
    .rbr_rd       (rbr_rd),
    .thr_wr       (thr_wr),
    .iir_rd       (iir_rd),
    .msr_rd       (msr_rd),
    .ier_wr       (ier_wr),
    .ier_wdata    (ier_wdata),
    .bus_strobe_n (bus_strobe_n),
    .ier_rdata    (ier_rdata),
    .irq_id       (irq_id),
    .irq          (irq),
    .irq_edge     (irq_edge)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // one clock; inputs change and outputs are sampled 1 ns after the edge
  task automatic cyc();
    @(posedge clk);
    #1;
    src_set = '0; lsr_rd = 0; rbr_rd = 0; thr_wr = 0; iir_rd = 0; msr_rd = 0;
    ier_wr = 0;
  endtask

  task automatic wr_ier(input logic [3:0] v);
    ier_wr = 1; ier_wdata = v;
    cyc();
  endtask

  task automatic clear_all();
    lsr_rd = 1; rbr_rd = 1; thr_wr = 1; msr_rd = 1;
    cyc();
    legacy_mode = 0;
  endtask

  task automatic t_reset();
    #5;
    chk("R1", "irq in reset", {7'd0, irq}, 8'd0);
    chk("R1", "id in reset", {5'd0, irq_id}, 8'h01);
    chk("R1", "edge in reset", {7'd0, irq_edge}, 8'd0);
    @(posedge clk); #1; rst_n = 1;
    repeat (3) cyc();
    chk("R1", "irq after reset", {7'd0, irq}, 8'd0);
    chk("R1", "id after reset", {5'd0, irq_id}, 8'h01);
    chk("R1", "ier after reset", {4'd0, ier_rdata}, 8'd0);
  endtask

  task automatic t_enable_gate();
    src_set = 4'b1000; cyc();
    chk("R2", "irq with source disabled", {7'd0, irq}, 8'd0);
    chk("R2", "id with source disabled", {5'd0, irq_id}, 8'h01);
    wr_ier(4'b1000);
    chk("R12", "ier readback", {4'd0, ier_rdata}, 8'h08);
    chk("R2", "irq after enable", {7'd0, irq}, 8'd1);
    chk("R2", "id after enable", {5'd0, irq_id}, 8'h00);
    wr_ier(4'b1111);
    chk("R12", "ier readback all", {4'd0, ier_rdata}, 8'h0f);
    clear_all();
  endtask

  task automatic t_priority();
    src_set = 4'b1111; cyc();
    chk("R3", "id line first", {5'd0, irq_id}, 8'h06);
    lsr_rd = 1; cyc();
    chk("R3", "id rx second", {5'd0, irq_id}, 8'h04);
    rbr_rd = 1; cyc();
    chk("R3", "id tx third", {5'd0, irq_id}, 8'h02);
    thr_wr = 1; cyc();
    chk("R3", "id modem last", {5'd0, irq_id}, 8'h00);
    msr_rd = 1; cyc();
    chk("R3", "id none", {5'd0, irq_id}, 8'h01);
    chk("R3", "irq none", {7'd0, irq}, 8'd0);
    src_set = 4'b1010; cyc();
    chk("R3", "rx over modem", {5'd0, irq_id}, 8'h04);
    clear_all();
  endtask

  task automatic t_service();
    for (int i = 0; i < 4; i++) begin
      src_set = 4'b0001 << i; cyc();
      chk("R4", "pending before service", {7'd0, irq}, 8'd1);
      case (i)
        0: lsr_rd = 1;
        1: rbr_rd = 1;
        2: thr_wr = 1;
        default: msr_rd = 1;
      endcase
      cyc();
      chk("R4", "id after own service", {5'd0, irq_id}, 8'h01);
      chk("R4", "irq after own service", {7'd0, irq}, 8'd0);
    end
  endtask

  task automatic t_iir();
    src_set = 4'b0110; cyc();
    iir_rd = 1; cyc();
    chk("R5", "iir read while rx reported", {5'd0, irq_id}, 8'h04);
    rbr_rd = 1; cyc();
    chk("R5", "tx still pending", {5'd0, irq_id}, 8'h02);
    iir_rd = 1; cyc();
    chk("R5", "iir read clears tx", {5'd0, irq_id}, 8'h01);
    chk("R5", "irq after iir read", {7'd0, irq}, 8'd0);
  endtask

  task automatic t_set_wins();
    src_set = 4'b0010; rbr_rd = 1; cyc();
    chk("R6", "set beats clear (idle)", {5'd0, irq_id}, 8'h04);
    src_set = 4'b0010; rbr_rd = 1; cyc();
    chk("R6", "set beats clear (pending)", {7'd0, irq}, 8'd1);
    clear_all();
  endtask

  task automatic t_level();
    legacy_mode = 0;
    src_set = 4'b0101; cyc();
    lsr_rd = 1; cyc();
    chk("R7", "irq holds after service", {7'd0, irq}, 8'd1);
    chk("R7", "id moves to tx", {5'd0, irq_id}, 8'h02);
    cyc();
    chk("R7", "irq still high", {7'd0, irq}, 8'd1);
    thr_wr = 1; cyc();
    chk("R7", "irq falls when empty", {7'd0, irq}, 8'd0);
  endtask

  task automatic t_legacy();
    legacy_mode = 1;
    src_set = 4'b1011; cyc();
    chk("R8", "irq high with three", {7'd0, irq}, 8'd1);
    lsr_rd = 1; cyc();
    chk("R8", "gap after line service", {7'd0, irq}, 8'd0);
    chk("R8", "id rx during gap", {5'd0, irq_id}, 8'h04);
    cyc();
    chk("R8", "irq back after gap", {7'd0, irq}, 8'd1);
    rbr_rd = 1; cyc();
    chk("R8", "gap after rx service", {7'd0, irq}, 8'd0);
    cyc();
    chk("R8", "irq back for modem", {7'd0, irq}, 8'd1);
    msr_rd = 1; cyc();
    chk("R9", "irq low after last", {7'd0, irq}, 8'd0);
    cyc();
    chk("R9", "irq stays low", {7'd0, irq}, 8'd0);
    chk("R9", "id none", {5'd0, irq_id}, 8'h01);
    legacy_mode = 0;
  endtask

  task automatic t_ier_toggle();
    src_set = 4'b0010; cyc();
    wr_ier(4'b0000);
    chk("R10", "irq dropped by ier 0", {7'd0, irq}, 8'd0);
    chk("R10", "id none while masked", {5'd0, irq_id}, 8'h01);
    wr_ier(4'b1111);
    chk("R10", "irq re-asserted", {7'd0, irq}, 8'd1);
    chk("R10", "pending kept", {5'd0, irq_id}, 8'h04);
  endtask

  task automatic t_edge();
    bus_strobe_n = 0; #1;
    chk("R11", "edge low during access", {7'd0, irq_edge}, 8'd0);
    bus_strobe_n = 1; #1;
    chk("R11", "edge follows irq", {7'd0, irq_edge}, 8'd1);
    clear_all();
    chk("R11", "edge low when idle", {7'd0, irq_edge}, 8'd0);
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 0; legacy_mode = 0; src_set = '0;
    lsr_rd = 0; rbr_rd = 0; thr_wr = 0; iir_rd = 0; msr_rd = 0;
    ier_wr = 0; ier_wdata = '0; bus_strobe_n = 1;
    t_reset();
    t_enable_gate();
    t_priority();
    t_service();
    t_iir();
    t_set_wins();
    t_level();
    t_legacy();
    t_ier_toggle();
    t_edge();
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

endmodule